// File: doc/BRIEF.md
# Sample Stream Demultiplexer with Divided Ready Clock

This block sits between the digital output of a sampling converter and the wires that leave the chip. Every sample clock it takes one sample. In single-port mode it sends the samples out on port A at full rate. In split mode it deals consecutive samples onto port A and port B, so each port runs at half rate. It also drives a data-ready clock that a receiver uses to latch the ports.

In split mode the ready clock runs at a quarter or at half the sample rate. In single-port mode it always runs at half the sample rate. A synchronous realign input restarts the ready clock from a known phase. The port mode and the ready rate are taken from their pins only when a realign is recognised, so a mode change can never show a broken pair on the ports.

The sample stream has no valid/ready handshake and cannot be back-pressured. The converter produces a sample on every clock, and the block accepts one on every clock. A receiver that is too slow for the ready clock loses data; the block does not report this.

Top module: `demux_stage`

## Requirements
- R1: After reset, port A, port B and the ready clock are all 0. The active setting is single-port mode with a half-rate ready clock, whatever the pins show.
- R2: In single-port mode, port A carries, in each running cycle, the sample that was present 3 clocks earlier. Port B stays 0.
- R3: In split mode, port A shows the sample taken 4 clocks earlier and port B the sample taken 3 clocks earlier. Both ports change on the same clock edge and then hold for 2 clocks.
- R4: In split mode, the earlier sample of each pair is on port A and the later sample is on port B.
- R5: With the half-rate ready clock (single-port mode, or split mode with the quarter select at 0), the ready clock toggles on every running clock, starting low. In split mode the ports update on the edges where the ready clock falls.
- R6: With the quarter-rate ready clock (split mode with the quarter select at 1), the ready clock toggles every second running clock, starting low. The ports update on the clock edges between ready transitions.
- R7: The realign input passes through a 2-stage synchroniser. A realign pulse sampled at edge c is recognised at edge c+2. Recognition forces the ready clock low and holds it low for 2 further clocks. The ready clock then restarts from its initial phase. A realign that is held high keeps restarting the sequence.
- R8: The mode select (0 = single-port, 1 = split) and the quarter select (0 = half rate, 1 = quarter rate) are copied only at a recognition edge. At any other time they have no effect on the ports or on the ready clock.
- R9: Recognition of a realign into single-port mode clears port B on that same edge. During the restart hold, both ports keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 8 | Converter sample, one per clock |
| split_sel | input | 1 | Mode request: 0 single-port, 1 split |
| quarter_sel | input | 1 | Ready rate request in split mode: 0 half, 1 quarter |
| realign_in | input | 1 | Synchronous realign of the ready clock |
| port_a | output | 8 | First output port |
| port_b | output | 8 | Second output port, idle 0 in single-port mode |
| data_ready | output | 1 | Divided ready clock |

## Verification
The hardest case to reach from the ports is a realign that lands partway through a pair. It is harder still when the realign is held for several clocks, so that recognition repeats while the hold counter is already running. The stimulus gives realign pulses of different lengths at odd and even ready phases, and switches the mode in both directions. It also moves the mode pins with no realign, so that the bench can show the pins are ignored between recognitions. A behavioural model built from sample history queues predicts every output on every clock.

// File: rtl/demux_stage_pkg.sv
package demux_stage_pkg;
  typedef enum logic { MODE_SINGLE = 1'b0, MODE_SPLIT = 1'b1 } port_mode_e;
  typedef enum logic { RDY_HALF = 1'b0, RDY_QUARTER = 1'b1 } rdy_rate_e;
endpackage

// File: rtl/realign_sync.sv
module realign_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = shreg[STAGES-1];
endmodule

// File: rtl/ready_timing.sv
module ready_timing
  import demux_stage_pkg::*;
#(
  parameter int RESTART_DELAY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       recog,
  input  logic       split_req,
  input  logic       quarter_req,
  output logic       ready_clk,
  output logic       run_en,
  output logic       hold_busy,
  output logic       load_en,
  output logic       clear_b,
  output port_mode_e mode_q,
  output rdy_rate_e  rate_q
);
  localparam int HW = (RESTART_DELAY < 2) ? 1 : $clog2(RESTART_DELAY + 1);

  logic [HW-1:0] hold_cnt;
  logic [1:0]    phase;
  logic          quarter_act;

  assign hold_busy   = (hold_cnt != '0);
  assign run_en      = !recog && !hold_busy;
  assign quarter_act = (mode_q == MODE_SPLIT) && (rate_q == RDY_QUARTER);
  assign clear_b     = recog && !split_req;

  always_comb begin
    if (!run_en)                  load_en = 1'b0;
    else if (mode_q == MODE_SINGLE) load_en = 1'b1;
    else if (quarter_act)         load_en = !phase[0];
    else                          load_en = phase[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt  <= '0;
      phase     <= '0;
      ready_clk <= 1'b0;
      mode_q    <= MODE_SINGLE;
      rate_q    <= RDY_HALF;
    end else if (recog) begin
      hold_cnt  <= HW'(RESTART_DELAY);
      phase     <= '0;
      ready_clk <= 1'b0;
      mode_q    <= split_req ? MODE_SPLIT : MODE_SINGLE;
      rate_q    <= quarter_req ? RDY_QUARTER : RDY_HALF;
    end else if (hold_busy) begin
      hold_cnt  <= hold_cnt - 1'b1;
    end else begin
      phase <= phase + 2'd1;
      if (!quarter_act || phase[0]) ready_clk <= ~ready_clk;
    end
  end
endmodule

// File: rtl/sample_pipe.sv
module sample_pipe
  import demux_stage_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LAT_A = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sample_in,
  input  logic          load_en,
  input  logic          clear_b,
  input  port_mode_e    mode_q,
  output logic [DW-1:0] port_a,
  output logic [DW-1:0] port_b
);
  localparam int TAPS  = LAT_A - 1;
  localparam int TAP_A = LAT_A - 2;
  localparam int TAP_B = LAT_A - 3;

  logic [DW-1:0] tap [TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap[0] <= '0;
    else        tap[0] <= sample_in;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap[i] <= '0;
      else        tap[i] <= tap[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_a <= '0;
      port_b <= '0;
    end else if (clear_b) begin
      port_b <= '0;
    end else if (load_en) begin
      if (mode_q == MODE_SPLIT) begin
        port_a <= tap[TAP_A];
        port_b <= tap[TAP_B];
      end else begin
        port_a <= tap[TAP_B];
      end
    end
  end
endmodule

// File: rtl/demux_stage.sv
module demux_stage
  import demux_stage_pkg::*;
#(
  parameter int DW            = 8,
  parameter int LAT_A         = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int RESTART_DELAY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sample_in,
  input  logic          split_sel,
  input  logic          quarter_sel,
  input  logic          realign_in,
  output logic [DW-1:0] port_a,
  output logic [DW-1:0] port_b,
  output logic          data_ready
);
  logic       recog;
  logic       run_en;
  logic       hold_busy;
  logic       load_en;
  logic       clear_b;
  port_mode_e mode_q;
  rdy_rate_e  rate_q;

  realign_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(realign_in), .sync_out(recog)
  );

  ready_timing #(.RESTART_DELAY(RESTART_DELAY)) u_timing (
    .clk(clk), .rst_n(rst_n), .recog(recog),
    .split_req(split_sel), .quarter_req(quarter_sel),
    .ready_clk(data_ready), .run_en(run_en), .hold_busy(hold_busy),
    .load_en(load_en), .clear_b(clear_b), .mode_q(mode_q), .rate_q(rate_q)
  );

  sample_pipe #(.DW(DW), .LAT_A(LAT_A)) u_pipe (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
    .load_en(load_en), .clear_b(clear_b), .mode_q(mode_q),
    .port_a(port_a), .port_b(port_b)
  );
endmodule

// File: rtl/demux_stage_chk.sv
module demux_stage_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] port_a,
  input logic [DW-1:0] port_b,
  input logic          data_ready,
  input logic          recog,
  input logic          run_en,
  input logic          hold_busy,
  input logic          load_en,
  input logic          split_on,
  input logic          quarter_on
);
  p_portb_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !split_on |-> port_b == '0);

  p_port_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_en) |-> $stable(port_a));

  p_half_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !(split_on && quarter_on) |=> data_ready != $past(data_ready));

  p_quarter_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && split_on && quarter_on && load_en |=> $stable(data_ready));

  p_recog_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recog |=> !data_ready);

  p_restart_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |-> !data_ready);

  p_mode_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(recog) |-> $stable(split_on) && $stable(quarter_on));
endmodule

bind demux_stage demux_stage_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_a(port_a), .port_b(port_b),
  .data_ready(data_ready), .recog(recog), .run_en(run_en),
  .hold_busy(hold_busy), .load_en(load_en),
  .split_on(mode_q == demux_stage_pkg::MODE_SPLIT),
  .quarter_on(rate_q == demux_stage_pkg::RDY_QUARTER)
);

// File: tb/demux_stage_tb.sv
module demux_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sample_in = '0;
  logic       split_sel = 1'b0;
  logic       quarter_sel = 1'b0;
  logic       realign_in = 1'b0;
  logic [7:0] port_a, port_b;
  logic       data_ready;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  demux_stage u_dut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .split_sel(split_sel),
    .quarter_sel(quarter_sel), .realign_in(realign_in),
    .port_a(port_a), .port_b(port_b), .data_ready(data_ready)
  );

  // Behavioural reference
  logic [7:0] hist[$];
  logic       m_s1, m_s2, m_split, m_quarter, m_dr;
  logic [7:0] m_a, m_b;
  int         m_hold, m_k;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < 8; i++) hist.push_back(8'h00);
      m_s1 = 0; m_s2 = 0; m_split = 0; m_quarter = 0; m_dr = 0;
      m_a = 0; m_b = 0; m_hold = 0; m_k = 0;
    end else begin
      hist.push_front(sample_in);
      void'(hist.pop_back());
      if (m_s2) begin
        m_hold = 2; m_k = 0; m_dr = 0;
        m_split = split_sel; m_quarter = quarter_sel;
        if (!m_split) m_b = 0;
      end else if (m_hold > 0) begin
        m_hold--;
      end else begin
        if (!m_split) m_a = hist[2];
        else if ((m_quarter && (m_k % 2 == 0)) || (!m_quarter && (m_k % 2 == 1))) begin
          m_a = hist[3];
          m_b = hist[2];
        end
        if (m_split && m_quarter) m_dr = ((m_k + 1) / 2) % 2;
        else                      m_dr = (m_k + 1) % 2;
        m_k++;
      end
      m_s2 = m_s1;
      m_s1 = realign_in;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic step(input logic [7:0] s);
    @(negedge clk);
    cycles++;
    check(m_split ? "R3" : "R2", port_a, m_a);
    check(m_split ? "R4" : "R9", port_b, m_b);
    check(m_hold > 0 ? "R7" : (m_split && m_quarter ? "R6" : "R5"), data_ready, m_dr);
    sample_in = s;
  endtask

  task automatic run(input int n, input int seed);
    for (int i = 0; i < n; i++) step(8'((i * 37 + seed) ^ (i >> 2)));
  endtask

  task automatic realign(input logic sp, input logic qt, input int len);
    split_sel = sp; quarter_sel = qt; realign_in = 1'b1;
    run(len, 11);
    realign_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    checks++; if (port_a !== 0 || port_b !== 0 || data_ready !== 0) begin
      fails++; $display("FAIL R1: actual %0h/%0h/%0b expected 0/0/0", port_a, port_b, data_ready);
    end
    run(20, 1);
    // R8: pins change with no realign
    split_sel = 1'b1; quarter_sel = 1'b1;
    run(12, 5);
    check("R8", port_b, 0);
    realign(1'b1, 1'b0, 1);
    run(30, 9);
    realign(1'b1, 1'b1, 1);
    run(31, 17);
    realign(1'b1, 1'b0, 3);
    run(27, 23);
    realign(1'b1, 1'b1, 2);
    run(25, 29);
    realign(1'b0, 1'b1, 1);
    run(4, 31);
    check("R9", port_b, 0);
    run(20, 41);
    realign(1'b1, 1'b0, 1);
    run(15, 43);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule